// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Controller

This block is the digital control path of a byte-addressed serial EEPROM that answers as a slave on a two-wire I2C bus. A system clock samples SCL and SDA; START and STOP conditions are found from those samples. The block checks a 7-bit device address made of the type code 1010 and three strap pins. After a write header it takes a two-byte word address. Data bytes collect in a page buffer. They are copied into a behavioural byte array during a timed internal write cycle, and that cycle starts only at STOP.

Reads use the running address counter. The host can read at the current address, or it can load an address with a write header, send a repeated START and then read (random read). Reads can also stream byte after byte. While the write cycle runs, the block refuses its device address, so a host can poll until programming is done. A write-protect input keeps the array unchanged. SDA is open-drain: the single output pulls the line low when set and releases it otherwise.

Top module: `ser_eeprom_slave`

## Requirements
- R1: The block acknowledges only a device byte whose upper seven bits are 1010 followed by the `strap` pins (bit 0 of that byte is R/W, 1 = read). Any other device byte gets no acknowledge, and the bus stays released until the next START.
- R2: A write header (device byte with R/W=0, high address byte, low address byte) followed by one data byte and STOP stores that byte at the given address. A later read returns it.
- R3: Word-address bits above the array size (2^ADDR_W bytes) are ignored. Address 16'hF9C3 with ADDR_W=11 selects location 11'h1C3.
- R4: Each accepted data byte advances only the low PAGE_W (6) address bits. Bytes beyond 64 in one write wrap inside the page and overwrite earlier buffered bytes. The upper address bits never change.
- R5: Buffered data reaches the array only after STOP. A repeated-START random read of the same location before STOP returns the old value.
- R6: For WR_CYCLES clocks after a STOP that ends a write with data, the device byte is not acknowledged. After that time it is acknowledged again.
- R7: With `wp` high, the device byte and both address bytes are acknowledged, but the first data byte is not. The array is unchanged and no write cycle starts.
- R8: A current-address read returns the byte at the last accessed address plus one. After address 2^ADDR_W-1 it returns the byte at address 0.
- R9: During a read, each master acknowledge makes the block send the next byte, with the counter wrapping from the top address to 0. A master not-acknowledge leaves SDA released.
- R10: `sda_oe` is low in reset, and it changes only while the sampled SCL is low, except when START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap | input | 3 | Low three bits of the device address |
| wp | input | 1 | Write protect, high blocks programming |
| sda_oe | output | 1 | Pulls SDA low when high, releases it when low |

## Verification
The assertions check these rules on every clock. No device acknowledge is given during the write cycle. A protected data byte ends the transfer with SDA released. Each stored byte leaves the upper address bits unchanged and adds one to the low bits, modulo the page. The write cycle starts only after a detected STOP. SDA changes only while SCL is low. A master not-acknowledge releases SDA. The bench scenarios are needed to show that data reaches the array and can be read back. They also cover the overwrite order of a page wrap, the visible delay of commit until STOP, address masking, current-address and streaming wrap at the array top, and the number of refused polls.

// File: rtl/see_pkg.sv
package see_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_AH, ST_AH_ACK,
    ST_AL, ST_AL_ACK, ST_WD, ST_WD_ACK, ST_RD, ST_RACK
  } bus_state_t;
  localparam logic [3:0] DEV_TYPE = 4'b1010;
endpackage

// File: rtl/see_bus_sampler.sv
module see_bus_sampler (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_m, sda_m, scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_m <= 1'b1; sda_m <= 1'b1;
      scl_lvl <= 1'b1; sda_lvl <= 1'b1;
      scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i;  sda_m <= sda_i;
      scl_lvl <= scl_m; sda_lvl <= sda_m;
      scl_p <= scl_lvl; sda_p <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_p;
  assign scl_fall  = ~scl_lvl & scl_p;
  assign start_det = scl_lvl & scl_p & sda_p & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_p & ~sda_p & sda_lvl;
endmodule

// File: rtl/see_page_buf.sv
module see_page_buf #(
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAGE_W-1:0] widx,
  input  logic [7:0]        wdata,
  input  logic              clr,
  input  logic [PAGE_W-1:0] ridx,
  output logic [7:0]        rdata,
  output logic              rvalid,
  output logic              any_valid
);
  localparam int PAGE = 1 << PAGE_W;
  logic [7:0]      bytes [PAGE];
  logic [PAGE-1:0] vld;

  always_ff @(posedge clk) begin
    if (we) bytes[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vld <= '0;
    else if (we)    vld[widx] <= 1'b1;
  end

  assign rdata     = bytes[ridx];
  assign rvalid    = vld[ridx];
  assign any_valid = |vld;
endmodule

// File: rtl/see_array.sv
module see_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 6,
  parameter int WR_CYCLES = 5000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe
);
  import see_pkg::*;

  localparam int PAGE = 1 << PAGE_W;
  localparam int TW   = $clog2(WR_CYCLES + 1);
  localparam int UPW  = ADDR_W - PAGE_W;

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  bus_state_t        state;
  logic [3:0]        bitcnt;
  logic [7:0]        rx, tx, hi;
  logic              rw, mack;
  logic [ADDR_W-1:0] addr_cnt;
  logic [UPW-1:0]    page_base;

  logic              busy;
  logic [TW-1:0]     tmr;
  logic              buf_we, buf_clr, buf_rvalid, buf_any;
  logic [7:0]        buf_rdata;
  logic              mem_we;
  logic [7:0]        rd_byte;

  see_bus_sampler u_samp (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  see_page_buf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst(rst), .we(buf_we), .widx(addr_cnt[PAGE_W-1:0]),
    .wdata(rx), .clr(buf_clr), .ridx(tmr[PAGE_W-1:0]),
    .rdata(buf_rdata), .rvalid(buf_rvalid), .any_valid(buf_any)
  );

  see_array #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr({page_base, tmr[PAGE_W-1:0]}),
    .wdata(buf_rdata), .raddr(addr_cnt), .rdata(rd_byte)
  );

  wire dev_match = (rx[7:4] == DEV_TYPE) && (rx[3:1] == strap);
  wire byte_done = scl_fall && (bitcnt == 4'd8);

  assign buf_we  = byte_done && (state == ST_WD) && !wp;
  assign mem_we  = busy && (tmr < TW'(PAGE)) && buf_rvalid;
  assign buf_clr = busy && (tmr == TW'(WR_CYCLES - 1));

  // internal write cycle timer; commit walks the page buffer one slot per clock
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (busy) begin
      if (tmr == TW'(WR_CYCLES - 1)) busy <= 1'b0;
      tmr <= tmr + 1'b1;
    end else if (stop_det && buf_any) begin
      busy <= 1'b1;
      tmr  <= '0;
    end
  end

  // bus protocol engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      rx        <= '0;
      tx        <= '0;
      hi        <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      addr_cnt  <= '0;
      page_base <= '0;
      sda_oe    <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        ST_DEV, ST_AH, ST_AL, ST_WD: begin
          rx     <= {rx[6:0], sda_lvl};
          bitcnt <= bitcnt + 1'b1;
        end
        ST_RD:   bitcnt <= bitcnt + 1'b1;
        ST_RACK: mack   <= ~sda_lvl;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state)
        ST_DEV: if (byte_done) begin
          if (dev_match && !busy) begin
            rw     <= rx[0];
            sda_oe <= 1'b1;
            state  <= ST_DEV_ACK;
          end else begin
            state  <= ST_IDLE;
          end
        end
        ST_DEV_ACK, ST_RACK: begin
          if ((state == ST_DEV_ACK && rw) || (state == ST_RACK && mack)) begin
            tx       <= rd_byte;
            sda_oe   <= ~rd_byte[7];
            addr_cnt <= addr_cnt + 1'b1;
            bitcnt   <= '0;
            state    <= ST_RD;
          end else if (state == ST_DEV_ACK) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_AH;
          end else begin
            sda_oe <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        ST_AH: if (byte_done) begin
          hi     <= rx;
          sda_oe <= 1'b1;
          state  <= ST_AH_ACK;
        end
        ST_AL: if (byte_done) begin
          addr_cnt <= ADDR_W'({hi, rx});
          sda_oe   <= 1'b1;
          state    <= ST_AL_ACK;
        end
        ST_WD: if (byte_done) begin
          if (wp) begin
            state <= ST_IDLE;
          end else begin
            page_base <= addr_cnt[ADDR_W-1:PAGE_W];
            addr_cnt[PAGE_W-1:0] <= addr_cnt[PAGE_W-1:0] + 1'b1;
            sda_oe <= 1'b1;
            state  <= ST_WD_ACK;
          end
        end
        ST_AH_ACK: begin sda_oe <= 1'b0; bitcnt <= '0; state <= ST_AL; end
        ST_AL_ACK, ST_WD_ACK: begin sda_oe <= 1'b0; bitcnt <= '0; state <= ST_WD; end
        ST_RD: begin
          if (bitcnt == 4'd8) begin
            sda_oe <= 1'b0;
            state  <= ST_RACK;
          end else begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
        default: ;
      endcase
    end
  end

  // R6: no device acknowledge is ever issued while the write cycle runs
  a_r6_busy_nack: assert property (@(posedge clk) disable iff (rst)
    busy |-> (state != ST_DEV_ACK));

  // R7: a protected data byte ends the transfer with SDA released
  a_r7_wp_data_nack: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WD && byte_done && wp) |=> (state == ST_IDLE && !sda_oe));

  // R4: a stored byte keeps the upper address bits and steps the low bits modulo the page
  a_r4_upper_stable: assert property (@(posedge clk) disable iff (rst)
    buf_we |=> $stable(addr_cnt[ADDR_W-1:PAGE_W]));
  a_r4_low_step: assert property (@(posedge clk) disable iff (rst)
    buf_we |=> (addr_cnt[PAGE_W-1:0] == $past(addr_cnt[PAGE_W-1:0]) + 1'b1));

  // R5: the write cycle begins only right after a detected STOP
  a_r5_commit_on_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det));

  // R10: SDA drive changes only with SCL low, apart from START/STOP release
  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && !$past(start_det) && !$past(stop_det)) |-> !scl_lvl);

  // R9: a master not-acknowledge leaves SDA released
  a_r9_nack_release: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RACK && scl_fall && !mack && !start_det && !stop_det) |=> !sda_oe);
endmodule

// File: tb/tb_ser_eeprom_slave.sv
module tb_ser_eeprom_slave;
  localparam int AW  = 11;
  localparam int WRC = 400;
  localparam int H   = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [AW-1:0] AMASK = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_h = 1'b1;
  logic sda_h_low = 1'b0;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_bus;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 1'b0;

  assign sda_bus = !(sda_h_low || sda_oe);
  always #2 clk = ~clk;

  ser_eeprom_slave #(.ADDR_W(AW), .PAGE_W(6), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rst(rst), .scl_i(scl_h), .sda_i(sda_bus),
    .strap(STRAP), .wp(wp), .sda_oe(sda_oe)
  );

  // {word address, data}; 16'hF9C3 carries junk bits above the array (R3)
  localparam logic [23:0] VEC [6] = '{
    {16'h0000, 8'h5A}, {16'h07FF, 8'hA5}, {16'hF9C3, 8'h3C},
    {16'h0210, 8'h81}, {16'h0101, 8'h7E}, {16'h0455, 8'hC9}
  };

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_h_low = 1'b0; wc(H); scl_h = 1'b1; wc(H);
    sda_h_low = 1'b1; wc(H); scl_h = 1'b0; wc(2);
  endtask

  task automatic bus_stop;
    sda_h_low = 1'b1; wc(H); scl_h = 1'b1; wc(H);
    sda_h_low = 1'b0; wc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_h_low = !b[i]; wc(H); scl_h = 1'b1; wc(H); scl_h = 1'b0; wc(2);
    end
    sda_h_low = 1'b0; wc(H); scl_h = 1'b1; wc(H/2);
    ack = !sda_bus; wc(H/2); scl_h = 1'b0; wc(2);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_h_low = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wc(H); scl_h = 1'b1; wc(H/2); b = {b[6:0], sda_bus}; wc(H/2); scl_h = 1'b0; wc(2);
    end
    sda_h_low = give_ack; wc(H); scl_h = 1'b1; wc(H); scl_h = 1'b0; wc(2);
    sda_h_low = 1'b0;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic hdr(input logic [15:0] a, output logic [2:0] acks);
    logic k;
    bus_start;
    send_byte(dev(1'b0), k);     acks[2] = k;
    send_byte(a[15:8], k);       acks[1] = k;
    send_byte(a[7:0], k);        acks[0] = k;
  endtask

  task automatic poll(output int nacks);
    logic k;
    nacks = 0;
    for (int i = 0; i < 40; i++) begin
      bus_start; send_byte(dev(1'b0), k); bus_stop;
      if (k) break;
      nacks++;
    end
  endtask

  task automatic byte_write(input logic [15:0] a, input logic [7:0] d, output int nacks);
    logic [2:0] acks; logic k;
    hdr(a, acks); send_byte(d, k); bus_stop; poll(nacks);
  endtask

  task automatic rand_read(input logic [15:0] a, output logic [7:0] d);
    logic [2:0] acks; logic k;
    hdr(a, acks); bus_start; send_byte(dev(1'b1), k); recv_byte(1'b0, d); bus_stop;
  endtask

  task automatic cur_read(output logic [7:0] d);
    logic k;
    bus_start; send_byte(dev(1'b1), k); recv_byte(1'b0, d); bus_stop;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e;
    logic [2:0] acks;
    logic k;
    int nk, bad;

    wc(5);
    chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);
    rst = 1'b0; wc(5);
    chk(sda_oe == 1'b0, "R10 idle release", sda_oe, 0);

    // R1: wrong strap and wrong type code
    bus_start; send_byte({4'b1010, 3'b010, 1'b0}, k); bus_stop;
    chk(k == 1'b0, "R1 strap mismatch nack", k, 0);
    bus_start; send_byte({4'b1011, STRAP, 1'b0}, k);
    chk(sda_oe == 1'b0, "R1 released after mismatch", sda_oe, 0); bus_stop;
    chk(k == 1'b0, "R1 type mismatch nack", k, 0);
    bus_start; send_byte(dev(1'b0), k); bus_stop;
    chk(k == 1'b1, "R1 own address ack", k, 1);

    // table walk: byte write, busy polling, read back (R2, R3, R6)
    for (int v = 0; v < 6; v++) begin
      byte_write(VEC[v][23:8], VEC[v][7:0], nk);
      chk(nk >= 1 && nk < 40, "R6 busy nack then ack", nk, 1);
      rand_read({5'b0, VEC[v][8+AW-1:8] & AMASK}, d);
      chk(d == VEC[v][7:0], (v == 2) ? "R3 high bits ignored" : "R2 byte write", d, VEC[v][7:0]);
    end

    // R4: 66-byte page write wraps inside the page
    hdr(16'h0140, acks);
    bad = 0;
    for (int i = 0; i < 66; i++) begin
      send_byte(8'h30 + 8'(i), k);
      if (!k) bad++;
    end
    bus_stop; poll(nk);
    chk(bad == 0, "R4 page bytes acked", bad, 0);
    hdr(16'h0140, acks); bus_start; send_byte(dev(1'b1), k);
    bad = 0;
    for (int j = 0; j < 64; j++) begin
      recv_byte(j != 63, d);
      e = (j < 2) ? 8'h30 + 8'(64 + j) : 8'h30 + 8'(j);
      if (d != e) bad++;
    end
    bus_stop;
    chk(bad == 0, "R4 wrap overwrite, R9 sequential", bad, 0);

    // R4: start at page offset 62, third byte wraps to offset 0
    hdr(16'h07BE, acks);
    send_byte(8'h11, k); send_byte(8'h22, k); send_byte(8'h33, k);
    bus_stop; poll(nk);
    rand_read(16'h0780, d);
    chk(d == 8'h33, "R4 offset wrap to page start", d, 8'h33);
    rand_read(16'h07BF, d);
    chk(d == 8'h22, "R4 last page slot", d, 8'h22);
    rand_read(16'h07FF, d);
    chk(d == 8'hA5, "R4 upper bits unchanged", d, 8'hA5);

    // R5: commit only after STOP
    hdr(16'h0210, acks); send_byte(8'hEE, k);
    bus_start; send_byte(dev(1'b0), k); send_byte(8'h02, k); send_byte(8'h10, k);
    bus_start; send_byte(dev(1'b1), k); recv_byte(1'b0, d); bus_stop;
    chk(d == 8'h81, "R5 old data before stop", d, 8'h81);
    poll(nk);
    chk(nk >= 1, "R5 write cycle started at stop", nk, 1);
    rand_read(16'h0210, d);
    chk(d == 8'hEE, "R5 new data after stop", d, 8'hEE);

    // R7: write protect
    wp = 1'b1;
    hdr(16'h0101, acks);
    chk(acks == 3'b111, "R7 header acked", acks, 3'b111);
    send_byte(8'h00, k);
    chk(k == 1'b0, "R7 data nack", k, 0);
    bus_stop; poll(nk);
    chk(nk == 0, "R7 no write cycle", nk, 0);
    wp = 1'b0;
    rand_read(16'h0101, d);
    chk(d == 8'h7E, "R7 array unchanged", d, 8'h7E);

    // R8: current-address read and top wrap
    rand_read(16'h0454, d);
    cur_read(d);
    chk(d == 8'hC9, "R8 next address", d, 8'hC9);
    rand_read(16'h07FF, d);
    cur_read(d);
    chk(d == 8'h5A, "R8 wrap to zero", d, 8'h5A);

    // R9: streaming across the top, then master nack releases SDA
    hdr(16'h07FF, acks); bus_start; send_byte(dev(1'b1), k);
    recv_byte(1'b1, d);
    chk(d == 8'hA5, "R9 first streamed byte", d, 8'hA5);
    recv_byte(1'b0, d);
    chk(d == 8'h5A, "R9 stream wraps to zero", d, 8'h5A);
    wc(H);
    chk(sda_oe == 1'b0, "R9 nack releases sda", sda_oe, 0);
    bus_stop;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule